// File: doc/BRIEF.md
# Fault Status Register Group

This block gathers sixteen fault lines of an instrument controller into three host-visible registers. A condition register is a live, synchronised view of the fault inputs. An event register remembers that an enabled fault was seen. An enable register selects which faults may be recorded.

Event bits are sticky until the host reads the event register. That read returns the recorded bits and clears them in the same access. A service-request output stays high while any recorded event is pending, which lets the host poll or take an interrupt only when something worth reading has happened.

The register bus is a plain strobe interface. `bus_rd` and `bus_wr` qualify `bus_addr`, and read data appears on a registered output one cycle after the read strobe. The address map is: 0 = condition (read-only), 1 = event (read clears it), 2 = enable (read/write), 3 = unused and reads zero.

Top module: `fault_status_group`

## Requirements
- R1: The condition register shows each fault input two clock edges after the input changes, in both directions, with no latching. Reading address 0 returns it.
- R2: An event bit is set only while both its condition bit and its enable bit are 1. A fault whose enable bit is 0 never sets its event bit.
- R3: A set event bit stays set until a read of address 1, however the condition changes meanwhile. A fault lasting one cycle is therefore still recorded.
- R4: A read of address 1 returns the event register on `bus_rdata` one cycle later and clears every event bit at that same edge.
- R5: If a condition bit is set and enabled in the cycle of a clearing read, its event bit is set after the read.
- R6: `srq` is high exactly when any event bit is set. It drops in the cycle after a clearing read when no enabled condition is present.
- R7: Fault bits are: AC loss 1, over-temperature 2, foldback 3, over-voltage 4, chained shut-off 5, output off 6, interlock 7, enable line 8, under-voltage 9, power switch off 15. Bits 0 and 10 to 14 read zero in all three registers, and enable writes to them are ignored. Writing 0xFFFF to enable therefore reads back 0x83FE.
- R8: After reset the condition, event, enable and read-data registers are all zero, and `srq` is low.
- R9: A write to address 2 loads the enable register, which reads back at address 2. Writes to addresses 0, 1 and 3 change nothing.
- R10: `bus_rdata` holds the last read value until the next read. A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_in | input | 16 | Asynchronous fault lines, one per bit |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| srq | output | 1 | Service request, high while any event is pending |

## Verification
Directed patterns come first.
- All faults raised with every enable set. This separates live bits from reserved bits.
- A fault on a disabled bit. This shows that enable gates capture, not only the summary output.
- A one-cycle fault pulse. This shows that the event is held after the condition has gone.
- A fault held across a clearing read. This separates the "new event wins" rule from a plain clear.

After these, seeded random fault patterns with reads and writes interleaved at random addresses are compared each cycle against a bench model. This exposes timing slips in the two-stage synchroniser, the read-clear ordering and writes to read-only addresses.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   localparam int FSR_W = 16;

   // fault bit positions
   localparam int FSR_B_ACLOSS   = 1;
   localparam int FSR_B_OVERTEMP = 2;
   localparam int FSR_B_FOLDBACK = 3;
   localparam int FSR_B_OVERVOLT = 4;
   localparam int FSR_B_CHAINOFF = 5;
   localparam int FSR_B_OUTOFF   = 6;
   localparam int FSR_B_INTLOCK  = 7;
   localparam int FSR_B_ENLINE   = 8;
   localparam int FSR_B_UNDERVLT = 9;
   localparam int FSR_B_PWRSW    = 15;

   localparam logic [FSR_W-1:0] FSR_LIVE_DEFAULT =
      (FSR_W'(1) << FSR_B_ACLOSS)   | (FSR_W'(1) << FSR_B_OVERTEMP) |
      (FSR_W'(1) << FSR_B_FOLDBACK) | (FSR_W'(1) << FSR_B_OVERVOLT) |
      (FSR_W'(1) << FSR_B_CHAINOFF) | (FSR_W'(1) << FSR_B_OUTOFF)   |
      (FSR_W'(1) << FSR_B_INTLOCK)  | (FSR_W'(1) << FSR_B_ENLINE)   |
      (FSR_W'(1) << FSR_B_UNDERVLT) | (FSR_W'(1) << FSR_B_PWRSW);

   typedef enum logic [1:0] {
      FSR_A_COND = 2'd0,
      FSR_A_EVT  = 2'd1,
      FSR_A_EN   = 2'd2,
      FSR_A_NONE = 2'd3
   } fsr_addr_e;

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fsr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fsr_event_bank.sv
module fsr_event_bank #(
   parameter int           W    = 16,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic [W-1:0] en,
   input  logic         clr,
   output logic [W-1:0] evt
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         logic evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= (evt_q & ~clr) | (cond[i] & en[i]);
         end
         assign evt[i] = evt_q;
      end else begin : g_rsvd
         assign evt[i] = 1'b0;
      end
   end

   // R3: recorded bits are kept when no clearing read occurs
   p_evt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((evt & $past(evt)) == $past(evt)));

   // R2: an enabled condition is recorded at the next edge
   p_evt_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cond & en) != '0) |=> ((evt & $past(cond & en)) == $past(cond & en)));

   // R2: no event bit rises without its enable bit
   p_evt_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt & ~$past(evt) & ~$past(en)) == '0));

endmodule

// File: rtl/fsr_regbus.sv
module fsr_regbus
   import fsr_pkg::*;
#(
   parameter int           W    = 16,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   addr,
   input  logic         rd,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] cond,
   input  logic [W-1:0] evt,
   output logic [W-1:0] en,
   output logic         clr,
   output logic [W-1:0] rdata
);

   logic [W-1:0] en_q;
   logic [W-1:0] rdata_q;
   logic [W-1:0] rsel;
   logic         en_we;

   assign en_we = wr && (addr == FSR_A_EN);
   assign clr   = rd && (addr == FSR_A_EVT);

   always_comb begin
      case (addr)
         FSR_A_COND: rsel = cond;
         FSR_A_EVT:  rsel = evt;
         FSR_A_EN:   rsel = en_q;
         default:    rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= wdata & LIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata_q <= '0;
      else if (rd)  rdata_q <= rsel;
   end

   assign en    = en_q;
   assign rdata = rdata_q;

   // R9: an enable write shows up masked at the next edge
   p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (en_q == ($past(wdata) & LIVE)));

   // R9: enable changes only through its own address
   p_en_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_q));

   // R10: read data holds between reads
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata_q));

endmodule

// File: rtl/fault_status_group.sv
module fault_status_group
   import fsr_pkg::*;
#(
   parameter int           WIDTH       = FSR_W,
   parameter int           SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] LIVE_MASK = FSR_LIVE_DEFAULT[WIDTH-1:0]
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] fault_in,
   input  logic [1:0]       bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   output logic             srq
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("fault_status_group: WIDTH out of range");
   end

   logic [WIDTH-1:0] sync_q;
   logic [WIDTH-1:0] cond;
   logic [WIDTH-1:0] evt;
   logic [WIDTH-1:0] en;
   logic             clr;

   fsr_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fault_in),
      .q     (sync_q)
   );

   assign cond = sync_q & LIVE_MASK;

   fsr_event_bank #(.W(WIDTH), .LIVE(LIVE_MASK)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond),
      .en    (en),
      .clr   (clr),
      .evt   (evt)
   );

   fsr_regbus #(.W(WIDTH), .LIVE(LIVE_MASK)) u_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .rd    (bus_rd),
      .wr    (bus_wr),
      .wdata (bus_wdata),
      .cond  (cond),
      .evt   (evt),
      .en    (en),
      .clr   (clr),
      .rdata (bus_rdata)
   );

   assign srq = |evt;

   // R7: reserved positions stay zero in every register
   p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((cond | evt | en) & ~LIVE_MASK) == '0));

   // R6: a clearing read with nothing new enabled drops the request
   p_srq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ((cond & en) == '0)) |=> !srq);

   // R5: an enabled condition during a clearing read keeps the request
   p_srq_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ((cond & en) != '0)) |=> srq);

endmodule

// File: tb/test_fault_status_group.sv
`timescale 1ns/1ps
module test_fault_status_group;

   localparam logic [15:0] LIVE = 16'h83FE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fault_in = '0;
   logic [1:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        srq;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_s1 = '0, m_s2 = '0, m_evt = '0, m_en = '0, m_rd = '0;
   logic [15:0] cur_f = '0;

   always #10 clk = ~clk;

   fault_status_group i_fault_status_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_in  (fault_in),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .srq       (srq)
   );

   function automatic logic [15:0] sel(input logic [1:0] a);
      case (a)
         2'd0: return m_s2;
         2'd1: return m_evt;
         2'd2: return m_en;
         default: return 16'h0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] f, input logic rd, input logic wr,
                       input logic [1:0] a, input logic [15:0] wd);
      logic [15:0] nrd, nevt, nen;
      fault_in = f; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      cur_f = f;
      @(posedge clk);
      nrd  = rd ? sel(a) : m_rd;
      nevt = ((rd && a == 2'd1) ? 16'h0 : m_evt) | (m_s2 & m_en);
      nen  = (wr && a == 2'd2) ? (wd & LIVE) : m_en;
      m_s2 = m_s1;
      m_s1 = f & LIVE;
      m_evt = nevt; m_en = nen; m_rd = nrd;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      chk(srq == (|m_evt), "R6 srq", {15'h0, srq}, {15'h0, |m_evt});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(cur_f, 1'b0, 1'b0, 2'd0, 16'h0);
   endtask

   task automatic rdchk(input logic [1:0] a, input logic [15:0] exp, input string tag);
      step(cur_f, 1'b1, 1'b0, a, 16'h0);
      chk(bus_rdata === exp, tag, bus_rdata, exp);
      chk(bus_rdata === m_rd, {tag, " model"}, bus_rdata, m_rd);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      step(cur_f, 1'b0, 1'b1, a, d);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      chk(srq == 1'b0, "R8 srq", {15'h0, srq}, 16'h0);
      chk(bus_rdata == 16'h0, "R8 rdata", bus_rdata, 16'h0);
      rdchk(2'd0, 16'h0, "R8 cond");
      rdchk(2'd1, 16'h0, "R8 evt");
      rdchk(2'd2, 16'h0, "R8 en");
      // R7 / R9 enable mask
      wr_reg(2'd2, 16'hFFFF);
      rdchk(2'd2, 16'h83FE, "R7 R9 enable readback");
      // R1 condition, all faults
      cur_f = 16'hFFFF;
      idle(2);
      rdchk(2'd0, 16'h83FE, "R1 R7 cond live");
      rdchk(2'd1, 16'h83FE, "R4 evt read");
      idle(1);
      chk(srq == 1'b1, "R5 srq after clear with fault held", {15'h0, srq}, 16'h1);
      // fault removed
      cur_f = 16'h0;
      idle(3);
      rdchk(2'd0, 16'h0, "R1 cond cleared");
      rdchk(2'd1, 16'h83FE, "R3 evt still set");
      chk(srq == 1'b0, "R6 srq drop after clear", {15'h0, srq}, 16'h0);
      rdchk(2'd1, 16'h0, "R4 evt cleared");
      // R2 disabled bit
      wr_reg(2'd2, 16'h0010);
      cur_f = 16'h0008;
      idle(4);
      chk(srq == 1'b0, "R2 srq disabled fault", {15'h0, srq}, 16'h0);
      rdchk(2'd0, 16'h0008, "R2 cond shows disabled fault");
      rdchk(2'd1, 16'h0, "R2 evt not latched");
      // R3 single-cycle pulse
      step(16'h0010, 1'b0, 1'b0, 2'd0, 16'h0);
      cur_f = 16'h0;
      idle(5);
      chk(srq == 1'b1, "R3 srq held", {15'h0, srq}, 16'h1);
      rdchk(2'd1, 16'h0010, "R3 pulse recorded");
      // R5 fault present exactly when clearing read hits
      cur_f = 16'h0010;
      idle(3);
      rdchk(2'd1, 16'h0010, "R5 read during fault");
      rdchk(2'd1, 16'h0010, "R5 event re-set after read");
      cur_f = 16'h0;
      idle(3);
      rdchk(2'd1, 16'h0010, "R5 drain");
      rdchk(2'd1, 16'h0, "R4 empty");
      // R9 writes to read-only addresses
      wr_reg(2'd0, 16'hFFFF);
      wr_reg(2'd1, 16'hFFFF);
      wr_reg(2'd3, 16'hFFFF);
      rdchk(2'd2, 16'h0010, "R9 enable untouched");
      rdchk(2'd1, 16'h0, "R9 evt untouched");
      rdchk(2'd0, 16'h0, "R9 cond untouched");
      // R10 unused address and hold
      wr_reg(2'd2, 16'h8002);
      rdchk(2'd2, 16'h8002, "R10 prior");
      idle(2);
      chk(bus_rdata == 16'h8002, "R10 rdata hold", bus_rdata, 16'h8002);
      rdchk(2'd3, 16'h0, "R10 unused address");
      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] f;
         logic rd, wr;
         logic [1:0] a;
         f = (($urandom % 4) == 0) ? 16'($urandom) : cur_f;
         rd = (($urandom % 3) == 0);
         wr = (($urandom % 8) == 0);
         a  = 2'($urandom);
         step(f, rd, wr, a, 16'($urandom));
         if (rd) chk(bus_rdata === m_rd, "R1 R4 R9 random read", bus_rdata, m_rd);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule